// File: doc/BRIEF.md
# Receive Descriptor Ring Filler

This block takes one received frame from a byte stream and places it in host memory through a ring of 8-byte receive descriptors. Each descriptor holds a 16-bit flag word, a 16-bit length and a 32-bit buffer address. Hardware may use a descriptor only while its Empty flag is set. The frame is first collected in an internal frame store. If it passes the acceptance checks, the block walks the ring from the current-descriptor pointer.

The block cuts the outgoing byte sequence into pieces of at most the programmed buffer length. That sequence is an optional zeroed control block, then the frame bytes, then four zero bytes that stand for the CRC. The block writes each piece into the buffer its descriptor points at and then writes the descriptor back with updated flags and length. It raises per-buffer and per-frame events.

When the ring runs out of Empty descriptors in the middle of a frame, the block sets a halt status bit and keeps the rest of the frame. It finishes that frame once software clears the halt bit. The input stream is held off with ready low until the frame has been fully placed or dropped.

Top module: `rx_ring_filler`

## Requirements
- R1: A completed frame is accepted only when `rxEnable` is high, `gracefulStop` is low and the halt status bit is clear. Otherwise it is dropped and the ring, the pointer and the events are untouched. `inReady` is high only while no frame is pending.
- R2: With `rejectShort` high, a frame of fewer than 60 bytes is dropped, and a 60-byte frame is accepted.
- R3: The bytes written are, in order: a zeroed control block, the frame, and 4 zero bytes. The control block has 8 + `padAlign` bytes when `parseDepth` is nonzero and is absent otherwise. Each buffer receives at most `maxBufLen` bytes. The descriptor length field is set to the number of bytes written to that buffer.
- R4: Only descriptors with Empty (flag bit 15) set are filled. A filled descriptor has Empty cleared. The first descriptor filled for a frame gets First (bit 10) when it is not also the last one. A descriptor filled after a restart never gets First.
- R5: On the descriptor that completes the frame, flag bits 10:0 are cleared and Last (bit 11) is set. Length-violation (bit 5) is set when frame length + 4 >= `maxFrameLen`. Short (bit 3) is set when frame length + 4 < 64.
- R6: A completing descriptor whose Interrupt flag (bit 12) is set pulses `evFrame` and sets `rxStat` bit 7-RING. A non-completing descriptor with Interrupt set pulses `evBuffer`.
- R7: Descriptor layout is flags in bits 63:48, length in bits 47:32 and buffer address in bits 31:0. After each descriptor, Wrap (bit 13) sends the pointer back to `ringBase`; otherwise the pointer advances by 8. `curDesc` holds the next descriptor address.
- R8: If the walk meets a non-Empty descriptor, or comes back to its start descriptor, with data left over, `rxStat` bit 23-RING is set and `curDesc` points past the last descriptor read. A non-Empty descriptor is left unchanged.
- R9: Writing a one to the halt bit through `statClear` clears it and resumes the remainder of the frame from `curDesc`. `rxStat` bits are cleared by writing ones to `statClear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rxEnable | input | 1 | Receive enable |
| gracefulStop | input | 1 | Stop request; frames are dropped while it is high |
| rejectShort | input | 1 | Drop frames under 60 bytes |
| parseDepth | input | 2 | Nonzero prepends a control block |
| padAlign | input | 5 | Extra control block bytes |
| maxBufLen | input | 16 | Maximum bytes per buffer |
| maxFrameLen | input | 16 | Length-violation threshold |
| ringBase | input | 32 | Ring base address |
| statClear | input | 32 | Write-one-to-clear for rxStat |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inLast | input | 1 | Final byte of the frame |
| inReady | output | 1 | Stream can accept a byte |
| memRe | output | 1 | Descriptor read; data returns next cycle |
| memWe | output | 1 | Memory write |
| memDesc | output | 1 | 1: 8-byte descriptor access, 0: single byte |
| memAddr | output | 32 | Memory address |
| memWdata | output | 64 | Write data (a byte write uses bits 7:0) |
| memRdata | input | 64 | Descriptor read data |
| evFrame | output | 1 | Frame-received event pulse |
| evBuffer | output | 1 | Buffer-received event pulse |
| rxStat | output | 32 | Sticky status: halt and frame-received bits |
| curDesc | output | 32 | Current descriptor pointer |

## Verification
The assertions assume that memory returns descriptor data exactly one cycle after `memRe`. They also assume `maxBufLen` is never zero and no frame is longer than the internal frame store. The stimulus uses a single-cycle memory model, buffer lengths from 16 to 64 and frames of at most 80 bytes. The halt bit is cleared only while the block is halted on a pending frame. Configuration inputs change only while the block is idle.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int FL_EMPTY = 15;
  localparam int FL_WRAP  = 13;
  localparam int FL_INTR  = 12;
  localparam int FL_LAST  = 11;
  localparam int FL_FIRST = 10;
  localparam int FL_LG    = 5;
  localparam int FL_SH    = 3;

  typedef struct packed {
    logic capture;     // store one stream byte
    logic clearFrame;  // frame consumed or dropped
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_FETCH, S_WAITD, S_WRITE, S_WB, S_HALT
  } fillState_t;
endpackage

// File: rtl/rx_ring_datapath.sv
module rx_ring_datapath
  import rx_ring_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  input  logic [7:0]       inData,
  input  logic [LEN_W-1:0] pos,
  input  logic [LEN_W-1:0] fcbLen,
  output logic [LEN_W-1:0] frameLen,
  output logic [7:0]       streamByte
);
  localparam int IDX_W = $clog2(BUF_BYTES);

  logic [7:0]       frameMem [BUF_BYTES];
  logic [LEN_W-1:0] rel;
  logic             full;

  assign full = (frameLen >= LEN_W'(BUF_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameLen <= '0;
    end else if (strobe.clearFrame) begin
      frameLen <= '0;
    end else if (strobe.capture && !full) begin
      frameLen <= frameLen + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.capture && !full && !strobe.clearFrame) begin
      frameMem[frameLen[IDX_W-1:0]] <= inData;
    end
  end

  // Byte at position pos of: zeroed control block, frame, zero CRC bytes
  always_comb begin
    rel = pos - fcbLen;
    if (pos >= fcbLen && rel < frameLen) begin
      streamByte = frameMem[rel[IDX_W-1:0]];
    end else begin
      streamByte = 8'h00;
    end
  end

  a_r3_store_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (frameLen == LEN_W'(BUF_BYTES) && !strobe.clearFrame) |=> (frameLen == LEN_W'(BUF_BYTES)));
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int RING   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxEnable,
  input  logic              gracefulStop,
  input  logic              rejectShort,
  input  logic [1:0]        parseDepth,
  input  logic [4:0]        padAlign,
  input  logic [LEN_W-1:0]  maxBufLen,
  input  logic [LEN_W-1:0]  maxFrameLen,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [31:0]       statClear,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              memRe,
  output logic              memWe,
  output logic              memDesc,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  input  logic [63:0]       memRdata,
  output logic              evFrame,
  output logic              evBuffer,
  output logic [31:0]       rxStat,
  output logic [ADDR_W-1:0] curDesc,
  output dpStrobe_t         strobe,
  output logic [LEN_W-1:0]  pos,
  output logic [LEN_W-1:0]  fcbLen,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [7:0]        streamByte
);
  localparam int HALT_BIT   = 23 - RING;
  localparam int FRAME_BIT  = 7 - RING;
  localparam int DESC_BYTES = 8;
  localparam int MIN_ACCEPT = 60;
  localparam int MIN_FRAME  = 64;
  localparam int CRC_BYTES  = 4;
  localparam int FCB_BASE   = 8;
  localparam logic [15:0] KEEP_HIGH = 16'hF800;

  fillState_t        state;
  logic [ADDR_W-1:0] curPtr, startPtr, descPtr, baseAligned, nextPtr;
  logic [15:0]       descFlags, newFlags;
  logic [15:0]       descLenUnused;
  logic [LEN_W-1:0]  total, chunkCnt, fcbNow, sizeWithCrc;
  logic              firstPend, accept, done, chunkEnd, wrapSel;
  logic [31:0]       statSet;

  assign baseAligned   = {ringBase[ADDR_W-1:3], 3'b000};
  assign fcbNow        = (parseDepth != 2'd0) ? LEN_W'(FCB_BASE) + LEN_W'(padAlign) : '0;
  assign sizeWithCrc   = frameLen + LEN_W'(CRC_BYTES);
  assign accept        = rxEnable && !gracefulStop && !rxStat[HALT_BIT] &&
                         !(rejectShort && frameLen < LEN_W'(MIN_ACCEPT));
  assign done          = (pos == total);
  assign chunkEnd      = (chunkCnt + 1'b1 == maxBufLen) || (pos + 1'b1 == total);
  assign wrapSel       = (state == S_WAITD) ? memRdata[48+FL_WRAP] : descFlags[FL_WRAP];
  assign nextPtr       = wrapSel ? baseAligned : curPtr + ADDR_W'(DESC_BYTES);
  assign descLenUnused = memRdata[47:32];

  assign inReady = (state == S_IDLE);
  assign curDesc = curPtr;
  assign fcbLen  = (state == S_CHECK) ? fcbNow : '0;

  always_comb begin
    strobe.capture    = inValid && inReady;
    strobe.clearFrame = (state == S_CHECK && !accept) || (state == S_WB && done);
  end

  // Flag word written back for the descriptor just filled
  always_comb begin
    newFlags = descFlags;
    newFlags[FL_EMPTY] = 1'b0;
    if (firstPend) newFlags[FL_FIRST] = 1'b1;
    if (done) begin
      newFlags = newFlags & KEEP_HIGH;
      newFlags[FL_LAST] = 1'b1;
      newFlags[FL_LG]   = (sizeWithCrc >= maxFrameLen);
      newFlags[FL_SH]   = (sizeWithCrc < LEN_W'(MIN_FRAME));
    end
  end

  always_comb begin
    memRe    = 1'b0;
    memWe    = 1'b0;
    memDesc  = 1'b0;
    memAddr  = curPtr;
    memWdata = '0;
    evFrame  = 1'b0;
    evBuffer = 1'b0;
    case (state)
      S_FETCH: begin
        memRe   = 1'b1;
        memDesc = 1'b1;
      end
      S_WRITE: begin
        memWe    = 1'b1;
        memAddr  = descPtr + ADDR_W'(chunkCnt);
        memWdata = {56'd0, streamByte};
      end
      S_WB: begin
        memWe    = 1'b1;
        memDesc  = 1'b1;
        memWdata = {newFlags, 16'(chunkCnt), 32'(descPtr)};
        evFrame  = done && descFlags[FL_INTR];
        evBuffer = !done && descFlags[FL_INTR];
      end
      default: ;
    endcase
  end

  always_comb begin
    statSet = '0;
    if (state == S_WAITD && !memRdata[48+FL_EMPTY]) statSet[HALT_BIT] = 1'b1;
    if (state == S_WB && !done && nextPtr == startPtr) statSet[HALT_BIT] = 1'b1;
    if (evFrame) statSet[FRAME_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      curPtr    <= {ringBase[ADDR_W-1:3], 3'b000};
      startPtr  <= '0;
      descPtr   <= '0;
      descFlags <= '0;
      pos       <= '0;
      total     <= '0;
      chunkCnt  <= '0;
      firstPend <= 1'b0;
      rxStat    <= '0;
    end else begin
      rxStat <= (rxStat & ~statClear) | statSet;
      case (state)
        S_IDLE: if (strobe.capture && inLast) state <= S_CHECK;
        S_CHECK: begin
          if (accept) begin
            total     <= fcbNow + sizeWithCrc;
            pos       <= '0;
            firstPend <= 1'b1;
            startPtr  <= curPtr;
            state     <= S_FETCH;
          end else begin
            state <= S_IDLE;
          end
        end
        S_FETCH: state <= S_WAITD;
        S_WAITD: begin
          if (memRdata[48+FL_EMPTY]) begin
            descFlags <= memRdata[63:48];
            descPtr   <= memRdata[ADDR_W-1:0];
            chunkCnt  <= '0;
            state     <= S_WRITE;
          end else begin
            curPtr <= nextPtr;
            state  <= S_HALT;
          end
        end
        S_WRITE: begin
          pos      <= pos + 1'b1;
          chunkCnt <= chunkCnt + 1'b1;
          if (chunkEnd) state <= S_WB;
        end
        S_WB: begin
          firstPend <= 1'b0;
          curPtr    <= nextPtr;
          if (done)                       state <= S_IDLE;
          else if (nextPtr == startPtr)   state <= S_HALT;
          else                            state <= S_FETCH;
        end
        S_HALT: begin
          if (statClear[HALT_BIT]) begin
            startPtr <= curPtr;
            state    <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_chunk_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB) |-> (chunkCnt != '0 && chunkCnt <= maxBufLen));
  a_r4_wb_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && memDesc) |-> !memWdata[48+FL_EMPTY]);
  a_r6_frame_event_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    evFrame |-> (memWe && memDesc && memWdata[48+FL_LAST]));
  a_r8_halt_leaves_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxStat[HALT_BIT]) |-> (pos != total));
  a_r9_halt_ptr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HALT && !statClear[HALT_BIT]) |=> $stable(curPtr));
  a_r1_no_ready_while_walking: assert property (@(posedge clk) disable iff (!rst_n)
    (memRe || memWe) |-> !inReady);
endmodule

// File: rtl/rx_ring_filler.sv
module rx_ring_filler
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 128,
  parameter int RING      = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxEnable,
  input  logic              gracefulStop,
  input  logic              rejectShort,
  input  logic [1:0]        parseDepth,
  input  logic [4:0]        padAlign,
  input  logic [LEN_W-1:0]  maxBufLen,
  input  logic [LEN_W-1:0]  maxFrameLen,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [31:0]       statClear,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              memRe,
  output logic              memWe,
  output logic              memDesc,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  input  logic [63:0]       memRdata,
  output logic              evFrame,
  output logic              evBuffer,
  output logic [31:0]       rxStat,
  output logic [ADDR_W-1:0] curDesc
);
  dpStrobe_t        strobe;
  logic [LEN_W-1:0] pos, fcbLen, frameLen;
  logic [7:0]       streamByte;
  logic [LEN_W-1:0] fcbHold;

  // The control block length is latched inside the total; the datapath
  // needs it during the walk, so keep a copy here.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fcbHold <= '0;
    else if (fcbLen != '0 || (strobe.capture && inLast)) fcbHold <= fcbLen;
  end

  rx_ring_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RING(RING)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .gracefulStop(gracefulStop),
    .rejectShort(rejectShort), .parseDepth(parseDepth), .padAlign(padAlign),
    .maxBufLen(maxBufLen), .maxFrameLen(maxFrameLen), .ringBase(ringBase),
    .statClear(statClear), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .memRe(memRe), .memWe(memWe), .memDesc(memDesc), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .evFrame(evFrame),
    .evBuffer(evBuffer), .rxStat(rxStat), .curDesc(curDesc), .strobe(strobe),
    .pos(pos), .fcbLen(fcbLen), .frameLen(frameLen), .streamByte(streamByte)
  );

  rx_ring_datapath #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inData(inData), .pos(pos),
    .fcbLen(fcbHold), .frameLen(frameLen), .streamByte(streamByte)
  );
endmodule

// File: tb/tb_rx_ring_filler.sv
module tb_rx_ring_filler;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] EMPTY = 16'h8000, WRAP = 16'h2000, INTR = 16'h1000;
  localparam logic [15:0] LAST = 16'h0800, FIRST = 16'h0400, LG = 16'h0020, SH = 16'h0008;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rxEnable, gracefulStop, rejectShort;
  logic [1:0] parseDepth;
  logic [4:0] padAlign;
  logic [15:0] maxBufLen, maxFrameLen;
  logic [31:0] ringBase, statClear;
  logic inValid, inLast, inReady;
  logic [7:0] inData;
  logic memRe, memWe, memDesc, evFrame, evBuffer;
  logic [31:0] memAddr, rxStat, curDesc;
  logic [63:0] memWdata, memRdata;

  logic [7:0] mem [512];
  int nChecks = 0, nFail = 0, nF = 0, nB = 0, expIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_filler dut (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .gracefulStop(gracefulStop),
    .rejectShort(rejectShort), .parseDepth(parseDepth), .padAlign(padAlign),
    .maxBufLen(maxBufLen), .maxFrameLen(maxFrameLen), .ringBase(ringBase),
    .statClear(statClear), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inReady(inReady), .memRe(memRe), .memWe(memWe), .memDesc(memDesc),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .evFrame(evFrame), .evBuffer(evBuffer), .rxStat(rxStat), .curDesc(curDesc)
  );

  // One-cycle memory model, big-endian descriptor packing
  always @(posedge clk) begin
    if (memRe) begin
      for (int i = 0; i < 8; i++) memRdata[63-8*i -: 8] <= mem[9'(memAddr + i)];
    end
    if (memWe) begin
      if (memDesc) begin
        for (int i = 0; i < 8; i++) mem[9'(memAddr + i)] <= memWdata[63-8*i -: 8];
      end else begin
        mem[memAddr[8:0]] <= memWdata[7:0];
      end
    end
    if (evFrame) nF++;
    if (evBuffer) nB++;
  end

  function automatic logic [7:0] pat(int n, int i);
    return 8'(i * 7 + n + 3);
  endfunction

  function automatic logic [15:0] origFlags(int idx);
    return EMPTY | INTR | ((idx == 3) ? WRAP : 16'h0);
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setDesc(int idx, logic [15:0] fl);
    logic [31:0] bp;
    bp = 32'h100 + 32'(idx * 64);
    mem[idx*8]   = fl[15:8];
    mem[idx*8+1] = fl[7:0];
    mem[idx*8+2] = 8'h00;
    mem[idx*8+3] = 8'h00;
    for (int i = 0; i < 4; i++) mem[idx*8+4+i] = bp[31-8*i -: 8];
  endtask

  task automatic initRing();
    for (int i = 0; i < 4; i++) setDesc(i, origFlags(i));
    for (int i = 256; i < 512; i++) mem[i] = 8'hEE;
  endtask

  task automatic sendFrame(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData  = pat(n, i);
      inLast  = (i == n - 1);
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 3000; i++) begin
      if (inReady || rxStat[23]) break;
      @(negedge clk);
    end
  endtask

  task automatic pulseClear(logic [31:0] m);
    @(negedge clk);
    statClear = m;
    @(negedge clk);
    statClear = '0;
  endtask

  task automatic checkDesc(int idx, int k, int n, int fcb, int mbl, bit isFirst,
                           bit isLast, int maxFrm, string req);
    int total, expLen, mism, p;
    logic [15:0] ef, fl, ln;
    logic [7:0] e;
    total  = fcb + n + 4;
    expLen = total - k * mbl;
    if (expLen > mbl) expLen = mbl;
    ef = (origFlags(idx) & ~EMPTY) | (isFirst ? FIRST : 16'h0);
    if (isLast) begin
      ef = (ef & 16'hF800) | LAST;
      if (n + 4 >= maxFrm) ef = ef | LG;
      if (n + 4 < 64) ef = ef | SH;
    end
    fl = {mem[idx*8], mem[idx*8+1]};
    ln = {mem[idx*8+2], mem[idx*8+3]};
    check(req, "descriptor flags", fl, ef);
    check("R3", "descriptor length", ln, expLen);
    mism = 0;
    for (int j = 0; j < expLen; j++) begin
      p = k * mbl + j;
      e = (p >= fcb && p - fcb < n) ? pat(n, p - fcb) : 8'h00;
      if (mem[256 + idx*64 + j] != e) mism++;
    end
    check("R3", "buffer byte mismatches", mism, 0);
  endtask

  task automatic runFrame(int n, int mbl, int pd, int pad, int maxFrm, bit rej);
    int fcb, total, nd, f0, b0;
    @(negedge clk);
    maxBufLen = 16'(mbl); parseDepth = 2'(pd); padAlign = 5'(pad);
    maxFrameLen = 16'(maxFrm); rejectShort = rej;
    initRing();
    f0 = nF; b0 = nB;
    sendFrame(n);
    waitDone();
    fcb = (pd != 0) ? 8 + pad : 0;
    total = fcb + n + 4;
    nd = (total + mbl - 1) / mbl;
    for (int k = 0; k < nd; k++)
      checkDesc((expIdx + k) % 4, k, n, fcb, mbl, k == 0, k == nd - 1, maxFrm,
                (k == nd - 1) ? "R5" : "R4");
    expIdx = (expIdx + nd) % 4;
    check("R7", "pointer after frame", curDesc, expIdx * 8);
    check("R6", "frame events", nF - f0, 1);
    check("R6", "buffer events", nB - b0, nd - 1);
    check("R6", "frame status bit", rxStat[7], 1);
    pulseClear(32'h0000_0080);
  endtask

  task automatic runDrop(int n, string req);
    int f0, b0;
    initRing();
    f0 = nF; b0 = nB;
    sendFrame(n);
    waitDone();
    @(negedge clk);
    check(req, "ready after drop", inReady, 1);
    check(req, "descriptor untouched", {mem[expIdx*8], mem[expIdx*8+1], mem[expIdx*8+2], mem[expIdx*8+3]},
          {origFlags(expIdx), 16'h0});
    check(req, "pointer unchanged", curDesc, expIdx * 8);
    check(req, "no events", (nF - f0) + (nB - b0), 0);
  endtask

  initial begin
    int mbls[4] = '{16, 24, 40, 64};
    int ns[4] = '{1, 21, 44, 61};
    int s, f0, b0;
    rxEnable = 1; gracefulStop = 0; rejectShort = 0; parseDepth = 0; padAlign = 0;
    maxBufLen = 16; maxFrameLen = 1518; ringBase = 0; statClear = 0;
    inValid = 0; inLast = 0; inData = 0; memRdata = '0;
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", inReady, 1);
    check("R7", "pointer after reset", curDesc, 0);
    check("R8", "status after reset", rxStat, 0);

    // R3 sweep over buffer length, control block and frame length
    for (int a = 0; a < 4; a++)
      for (int m = 0; m < 3; m++)
        for (int c = 0; c < 4; c++) begin
          int fcb;
          fcb = (m == 0) ? 0 : ((m == 1) ? 8 : 13);
          if (fcb + ns[c] + 4 <= 4 * mbls[a])
            runFrame(ns[c], mbls[a], m, (m == 2) ? 5 : 0, 1518, 0);
        end

    // R5 length-violation and short boundaries
    runFrame(60, 64, 0, 0, 64, 0);
    runFrame(60, 64, 0, 0, 65, 0);
    runFrame(59, 64, 0, 0, 1518, 0);

    // R2 short-frame rejection
    rejectShort = 1;
    runDrop(59, "R2");
    runFrame(60, 64, 0, 0, 1518, 1);
    rejectShort = 0;

    // R1 enable and graceful stop
    rxEnable = 0;
    runDrop(30, "R1");
    rxEnable = 1; gracefulStop = 1;
    runDrop(30, "R1");
    gracefulStop = 0;

    // R8/R9 ring exhausted, back at start descriptor
    maxBufLen = 16; parseDepth = 0; maxFrameLen = 1518;
    s = expIdx;
    initRing();
    f0 = nF; b0 = nB;
    sendFrame(80);
    waitDone();
    check("R8", "halt bit on wrap-around", rxStat[23], 1);
    check("R8", "pointer back at start", curDesc, s * 8);
    check("R8", "ready low while halted", inReady, 0);
    check("R6", "buffer events before halt", nB - b0, 4);
    for (int k = 0; k < 4; k++) checkDesc((s + k) % 4, k, 80, 0, 16, k == 0, 0, 1518, "R4");
    initRing();
    f0 = nF; b0 = nB;
    pulseClear(32'h0080_0000);
    waitDone();
    check("R9", "halt cleared", rxStat[23], 0);
    checkDesc(s, 4, 80, 0, 16, 0, 0, 1518, "R9");
    checkDesc((s + 1) % 4, 5, 80, 0, 16, 0, 1, 1518, "R9");
    check("R9", "pointer after resume", curDesc, ((s + 2) % 4) * 8);
    check("R9", "frame event after resume", nF - f0, 1);
    check("R9", "buffer event after resume", nB - b0, 1);
    expIdx = (s + 2) % 4;
    pulseClear(32'h0000_0080);

    // R8 stop at a descriptor that is not Empty
    s = expIdx;
    initRing();
    setDesc((s + 2) % 4, origFlags((s + 2) % 4) & ~EMPTY);
    sendFrame(36);
    waitDone();
    check("R8", "halt bit on busy descriptor", rxStat[23], 1);
    check("R8", "pointer past busy descriptor", curDesc, ((s + 3) % 4) * 8);
    checkDesc(s, 0, 36, 0, 16, 1, 0, 1518, "R4");
    checkDesc((s + 1) % 4, 1, 36, 0, 16, 0, 0, 1518, "R4");
    check("R8", "busy descriptor untouched", {mem[((s+2)%4)*8], mem[((s+2)%4)*8+1]},
          origFlags((s + 2) % 4) & ~EMPTY);
    pulseClear(32'h0080_0000);
    waitDone();
    checkDesc((s + 3) % 4, 2, 36, 0, 16, 0, 1, 1518, "R9");
    check("R9", "pointer after busy resume", curDesc, s * 8);
    check("R1", "ready after frame", inReady, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule